// File: doc/BRIEF.md
# Daisy-Chain Command Frame Encoder with CRC-8

This block turns one command (a 5-bit device number, a 6-bit register number, 8 bits of data and a broadcast flag) into a 32-bit serial word for a chain of up to eight monitor devices. It packs the fields and writes the device number into its field with the bit order reversed. It then computes an 8-bit CRC over the 21 header bits and shifts the finished word out MSB first on a three-wire serial link that uses SPI mode 1. Device number 0 addresses the first device in the chain, and 0x1F addresses all of them.

A command is offered with a valid/ready handshake. Once it is accepted, the CRC is built one header bit per clock. Only after that does the chip select go low and the 32 bits go out. Each serial clock half lasts `HALF_DIV` system clocks. The last frame assembled stays visible on `frame_o`.

Top module: `cmd_frame_tx`

## Requirements
- R1: After reset, ready_o=1, cs_no=1, sclk_o=0, sdo_o=0 and frame_o=0.
- R2: A command is taken on a clock edge where valid_i and ready_o are both 1. ready_o stays 0 from that edge until cs_no returns high after the last bit, and frame_o does not change while cs_no is low.
- R3: Register number goes in frame bits 26:21, data in bits 20:13, broadcast flag in bit 12.
- R4: Frame bits 31:27 hold the device number bit-reversed: frame bit 31 is device bit 0 and frame bit 27 is device bit 4. An input of 0x1F therefore stays 0x1F.
- R5: Frame bits 10:3 equal frame bits 31:11, read as a 21-bit value, modulo x^8+x^5+x^3+x^2+x+1 (0x2F without its top term). No zero bits are appended before the division.
- R6: Frame bit 1 is 1. Bits 11, 2 and 0 are 0.
- R7: The CRC takes one clock per header bit. cs_no goes low exactly 21 clock edges after the accepting edge.
- R8: While cs_no is low, 32 bits go out MSB first. sclk_o idles low, sdo_o changes only as sclk_o rises, and the receiver samples on the falling edge. The word received equals frame_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command offered |
| ready_o | output | 1 | Encoder can accept a command |
| dev_addr_i | input | 5 | Device number (0x1F = all) |
| reg_addr_i | input | 6 | Register number |
| data_i | input | 8 | Data byte |
| bcast_i | input | 1 | Broadcast flag |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, MSB first |
| cs_no | output | 1 | Chip select, active low during a frame |
| frame_o | output | 32 | Last assembled frame |

## Verification
The assertions assume a clean reset and a stable system clock. They place no constraint on the command fields or on how valid_i toggles, because busy periods are guarded by ready_o. The stimulus drives every field value, random or at its extremes, such as all-ones and all-zeros words and device 0x1F. It asserts valid_i only while ready_o is high and drops it one step after the accepting edge, so each accepted command is followed through a complete frame.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;
  localparam int DEV_W   = 5;
  localparam int REG_W   = 6;
  localparam int DAT_W   = 8;
  localparam int CRC_W   = 8;
  localparam int HDR_W   = DEV_W + REG_W + DAT_W + 2;
  localparam int TAIL_W  = 3;
  localparam int FRAME_W = HDR_W + CRC_W + TAIL_W;
  localparam logic [CRC_W-1:0]  CRC_POLY = 8'h2F;
  localparam logic [TAIL_W-1:0] TAIL     = 3'b010;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [REG_W-1:0] rg;
    logic [DAT_W-1:0] dat;
    logic             bc;
  } cmd_t;
endpackage

// File: rtl/cmd_hdr_pack.sv
module cmd_hdr_pack
  import cmd_frame_pkg::*;
(
  input  cmd_t             cmd_i,
  output logic [HDR_W-1:0] hdr_o
);
  logic [DEV_W-1:0] dev_rev;

  for (genvar i = 0; i < DEV_W; i++) begin : g_rev
    assign dev_rev[i] = cmd_i.dev[DEV_W-1-i];
  end

  // trailing zero is frame bit 11, part of the CRC input
  assign hdr_o = {dev_rev, cmd_i.rg, cmd_i.dat, cmd_i.bc, 1'b0};
endmodule

// File: rtl/crc_serial.sv
module crc_serial #(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 8'h2F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] rem_q;

  // plain remainder: shift in data bit, subtract poly on overflow
  assign nxt_o = {rem_q[W-2:0], bit_i} ^ (rem_q[W-1] ? POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (clr_i)  rem_q <= '0;
    else if (en_i)   rem_q <= nxt_o;
  end
endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
  parameter int W        = 32,
  parameter int HALF_DIV = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         busy_o,
  output logic         sclk_o,
  output logic         sdo_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(W);

  logic [W-1:0]     sh_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic             ph_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; div_q <= '0; bit_q <= '0; ph_q <= 1'b0; busy_q <= 1'b0;
    end else if (start_i) begin
      sh_q <= word_i; div_q <= '0; bit_q <= '0; ph_q <= 1'b1; busy_q <= 1'b1;
    end else if (busy_q) begin
      if (div_q == DIV_W'(HALF_DIV - 1)) begin
        div_q <= '0;
        if (ph_q) begin
          ph_q <= 1'b0;
        end else if (bit_q == BIT_W'(W - 1)) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[W-2:0], 1'b0};
          ph_q  <= 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = busy_q & ph_q;
  assign sdo_o  = busy_q & sh_q[W-1];
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import cmd_frame_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  output logic        ready_o,
  input  logic [4:0]  dev_addr_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [7:0]  data_i,
  input  logic        bcast_i,
  output logic        sclk_o,
  output logic        sdo_o,
  output logic        cs_no,
  output logic [31:0] frame_o
);
  localparam int CNT_W = $clog2(HDR_W);

  typedef enum logic {ST_IDLE, ST_CRC} state_e;

  state_e             state_q;
  cmd_t               cmd_q;
  logic [HDR_W-1:0]   hdr;
  logic [CNT_W-1:0]   cnt_q;
  logic [CRC_W-1:0]   crc_nxt;
  logic [FRAME_W-1:0] frame_q, word;
  logic               tx_busy, accept, crc_en, crc_done;

  assign ready_o  = (state_q == ST_IDLE) && !tx_busy;
  assign accept   = valid_i && ready_o;
  assign crc_en   = (state_q == ST_CRC);
  assign crc_done = crc_en && (cnt_q == CNT_W'(HDR_W - 1));
  assign word     = {hdr, crc_nxt, TAIL};

  cmd_hdr_pack u_pack (.cmd_i(cmd_q), .hdr_o(hdr));

  crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .clr_i (accept),
    .en_i  (crc_en),
    .bit_i (hdr[CNT_W'(HDR_W - 1) - cnt_q]),
    .nxt_o (crc_nxt)
  );

  frame_shift #(.W(FRAME_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk_i, .rst_ni,
    .start_i (crc_done),
    .word_i  (word),
    .busy_o  (tx_busy),
    .sclk_o  (sclk_o),
    .sdo_o   (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cmd_q <= '0; cnt_q <= '0; frame_q <= '0;
    end else begin
      if (accept) begin
        state_q <= ST_CRC;
        cmd_q   <= '{dev: dev_addr_i, rg: reg_addr_i, dat: data_i, bc: bcast_i};
        cnt_q   <= '0;
      end else if (crc_done) begin
        state_q <= ST_IDLE;
        frame_q <= word;
      end else if (crc_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cs_no   = !tx_busy;
  assign frame_o = frame_q;
endmodule

// File: rtl/cmd_frame_tx_chk.sv
module cmd_frame_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_o,
  input logic        sclk_o,
  input logic        sdo_o,
  input logic        cs_no,
  input logic [31:0] frame_o
);
  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !ready_o);
  a_r2_frame_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(frame_o));
  a_r6_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> (frame_o[1] && !frame_o[0] && !frame_o[2] && !frame_o[11]));
  a_r7_crc_before_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(!ready_o));
  a_r8_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r8_sdo_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && !$rose(sclk_o)) |-> $stable(sdo_o));
endmodule

bind cmd_frame_tx cmd_frame_tx_chk u_chk (
  .clk_i, .rst_ni, .ready_o, .sclk_o, .sdo_o, .cs_no, .frame_o
);

// File: tb/cmd_frame_tx_bench.sv
module cmd_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HDR_BITS   = 21;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, bcast = 1'b0;
  logic [4:0]  dev = '0;
  logic [5:0]  rg = '0;
  logic [7:0]  dat = '0;
  logic        ready, sclk, sdo, cs_n;
  logic [31:0] frame;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_tx u_cmd_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .dev_addr_i(dev), .reg_addr_i(rg), .data_i(dat), .bcast_i(bcast),
    .sclk_o(sclk), .sdo_o(sdo), .cs_no(cs_n), .frame_o(frame)
  );

  function automatic logic [7:0] crc_byte(input logic [7:0] a);
    logic [7:0] c = a;
    for (int i = 0; i < 8; i++) begin
      if (c[7]) c = (c << 1) ^ 8'h2F;
      else      c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] exp_frame(input logic [4:0] d, input logic [5:0] r,
                                            input logic [7:0] x, input logic b);
    logic [4:0]  drev;
    logic [20:0] h;
    logic [7:0]  c;
    for (int i = 0; i < 5; i++) drev[i] = d[4-i];
    h = {drev, r, x, b, 1'b0};
    c = crc_byte({3'b000, h[20:16]});
    c = crc_byte(c ^ h[15:8]);
    c = c ^ h[7:0];
    return {h, c, 3'b010};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] d, input logic [5:0] r,
                      input logic [7:0] x, input logic b);
    logic [31:0] e, rx;
    int n;
    bit busy_ready;
    e = exp_frame(d, r, x, b);
    @(negedge clk);
    check("R2 ready before offer", {31'b0, ready}, 32'd1);
    dev = d; rg = r; dat = x; bcast = b; valid = 1'b1;
    @(posedge clk);
    #1 valid = 1'b0;
    n = 0; busy_ready = 0;
    forever begin
      @(negedge clk);
      if (!cs_n) break;
      if (ready) busy_ready = 1;
      @(posedge clk);
      n++;
    end
    check("R7 edges to cs low", n, HDR_BITS);
    rx = '0;
    for (int i = 0; i < 32; i++) begin
      @(negedge sclk);
      rx = {rx[30:0], sdo};
      if (ready) busy_ready = 1;
    end
    while (cs_n == 1'b0) @(negedge clk);
    check("R2 ready low while busy", {31'b0, busy_ready}, 32'd0);
    check("R2 ready after frame", {31'b0, ready}, 32'd1);
    check("R4 reversed device", {27'b0, frame[31:27]}, {27'b0, e[31:27]});
    check("R3 reg/data/bcast", {17'b0, frame[26:12]}, {17'b0, e[26:12]});
    check("R5 crc", {24'b0, frame[10:3]}, {24'b0, e[10:3]});
    check("R6 fixed bits", {28'b0, frame[11], frame[2:0]}, 32'b0010);
    check("R8 serial word", rx, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {27'b0, ready, cs_n, sclk, sdo, |frame}, {27'b0, 5'b11000});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {29'b0, ready, cs_n, sclk}, 32'b110);
    send(5'h00, 6'h00, 8'h00, 1'b0);
    send(5'h1F, 6'h3F, 8'hFF, 1'b1);
    send(5'h01, 6'h1D, 8'h55, 1'b0);
    send(5'h10, 6'h0D, 8'hAA, 1'b1);
    send(5'h07, 6'h14, 8'h3C, 1'b0);
    void'($urandom(32'd1234));
    for (int k = 0; k < 20; k++)
      send(5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule